// File: doc/BRIEF.md
# Channel-Interleaved Tenth-Order Synthesis Filter

This block runs a fixed-point all-pole recursive filter of order ten for many independent voice channels, all sharing one multiply-accumulate pipeline. The caller presents one excitation sample per clock, tagged with its channel number. The filtered sample leaves the block after a fixed number of cycles with the same tag, in the order the samples arrived. Each channel keeps its own ten most recent outputs and its own ten coefficients in small on-chip arrays indexed by channel.

The feedback path spans the whole pipeline, so a single channel cannot take a new sample every cycle. Full rate is reached by rotating through the channels. The caller sends sample i of every channel before sample i+1 of any channel. With at least as many channels as the pipeline has stages, every cycle carries one input and one output, and all ten multipliers do useful work.

A channel's coefficients are loaded through a write port while traffic flows. A per-channel clear input wipes a channel's output history, for example at the start of a call. A sample for a channel whose previous result is still in flight is refused, and a one-cycle error flag reports the refusal.

Top module: `chan_iir_synth`

## Requirements
- R1: A sample accepted in cycle c appears on `out_valid`/`out_ch`/`out_y` in cycle c+LAT, where LAT is the latency parameter (5 to 12, default 6). Its channel tag is unchanged, and outputs leave in acceptance order. No output appears without an accepted sample.
- R2: The output follows y(n) = round_sat((x(n)·4096 − Σ_{k=1..10} a_k·y(n−k)) mod 2^32 as a signed 32-bit value), where round_sat adds 2048 and shifts arithmetically right by 12 bits. x and y are 16-bit two's complement integers, and a_k is a 16-bit two's complement value with 12 fractional bits.
- R3: Each channel uses only its own coefficients and its own output history. A sample on one channel never changes the result of another channel.
- R4: With NCH ≥ LAT channels issued round-robin, one sample per cycle, the block delivers one output every cycle and raises no error.
- R5: A sample whose channel was accepted in one of the previous LAT−1 cycles is dropped. It produces no output and does not touch the history. `hazard` is high in the following cycle only.
- R6: A coefficient write with `coef_idx` k in 1..10 sets a_k of channel `coef_ch`. Index values 0 and 11 to 15 are ignored. A write applies to samples presented in later cycles, and a sample in the same cycle as the write still uses the old value.
- R7: A clear for channel ch zeroes that channel's ten history words. The next sample of that channel then gives y = x exactly, and other channels keep their history.
- R8: After reset, `out_valid` and `hazard` are low, and all histories and coefficients are zero, so each channel's first sample returns y = x.
- R9: Results above 32767 give 32767, and results below −32768 give −32768.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Excitation sample present |
| in_ch | input | CHW | Channel tag of the sample |
| in_x | input | 16 | Excitation sample, signed |
| coef_we | input | 1 | Coefficient write strobe |
| coef_ch | input | CHW | Channel of the coefficient write |
| coef_idx | input | 4 | Tap number 1..10 |
| coef_val | input | 16 | Coefficient, signed, 12 fractional bits |
| clr_en | input | 1 | Clear a channel's history |
| clr_ch | input | CHW | Channel to clear |
| out_valid | output | 1 | Filtered sample present |
| out_ch | output | CHW | Channel tag of the result |
| out_y | output | 16 | Filtered sample, signed |
| hazard | output | 1 | One-cycle pulse: previous sample was refused |

## Verification
Every cycle, the assertions check the timing side of the block. Each output must line up with a sample accepted exactly LAT cycles earlier and carry that sample's tag. The refusal flag must fire exactly when a sample collides with its channel's in-flight result. The arithmetic can only be shown by the bench's scenarios, which compare against an independent model. These scenarios cover per-channel separation, coefficient timing and ignored indices, history clearing, saturation at both rails, and the full-rate round-robin stream.

// File: rtl/chan_iir_pkg.sv
// Shared constants and the rounding/saturation function for the
// channel-interleaved synthesis filter. Assumes Q3.12 coefficients and
// a 32-bit wrapping accumulator.
package chan_iir_pkg;
    localparam int ORDER = 10;
    localparam int CW    = 16;
    localparam int DW    = 16;
    localparam int FRAC  = 12;
    localparam int AW    = 32;
    localparam int IDXW  = $clog2(ORDER + 1);
    localparam int YMAX  = 2 ** (DW - 1) - 1;
    localparam int YMIN  = -(2 ** (DW - 1));

    // Round half up by FRAC bits, then clamp to the DW-bit signed range.
    function automatic logic signed [DW-1:0] round_sat(input logic signed [AW-1:0] a);
        logic signed [AW:0] r;
        r = (AW+1)'(a) + (AW+1)'(2 ** (FRAC - 1));
        r = r >>> FRAC;
        if (r > (AW+1)'(YMAX)) return DW'(YMAX);
        if (r < (AW+1)'(YMIN)) return DW'(YMIN);
        return DW'(r);
    endfunction
endpackage

// File: rtl/iir_coef_store.sv
// Per-channel coefficient array. One write per cycle; the read port is
// combinational so the issuing sample sees the values before this edge's
// write. Assumes wr_ch and rd_ch are below NCH.
module iir_coef_store
    import chan_iir_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [CHW-1:0]        wr_ch,
    input  logic [IDXW-1:0]       wr_idx,
    input  logic signed [CW-1:0]  wr_val,
    input  logic [CHW-1:0]        rd_ch,
    output logic signed [CW-1:0]  rd_coef [ORDER]
);
    logic signed [CW-1:0] mem [NCH][ORDER];
    logic                 idx_ok;

    // Only tap numbers 1..ORDER address a coefficient.
    assign idx_ok = (wr_idx >= IDXW'(1)) && (wr_idx <= IDXW'(ORDER));

    // Store or clear coefficients.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++)
                for (int k = 0; k < ORDER; k++)
                    mem[c][k] <= '0;
        end else if (wr_en && idx_ok) begin
            mem[wr_ch][wr_idx - IDXW'(1)] <= wr_val;
        end
    end

    // Present the selected channel's taps.
    always_comb begin
        for (int k = 0; k < ORDER; k++)
            rd_coef[k] = mem[rd_ch][k];
    end
endmodule

// File: rtl/iir_hist_store.sv
// Per-channel output history: ten past outputs, newest at index 0.
// A write-back shifts a new output in; a clear zeroes one channel and wins
// over a write-back to the same channel in the same cycle.
module iir_hist_store
    import chan_iir_pkg::*;
#(
    parameter int NCH = 8,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wb_en,
    input  logic [CHW-1:0]        wb_ch,
    input  logic signed [DW-1:0]  wb_y,
    input  logic                  clr_en,
    input  logic [CHW-1:0]        clr_ch,
    input  logic [CHW-1:0]        rd_ch,
    output logic signed [DW-1:0]  rd_hist [ORDER]
);
    logic signed [DW-1:0] mem [NCH][ORDER];

    // Shift in results, apply clears, zero everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++)
                for (int k = 0; k < ORDER; k++)
                    mem[c][k] <= '0;
        end else begin
            if (wb_en) begin
                mem[wb_ch][0] <= wb_y;
                for (int k = 1; k < ORDER; k++)
                    mem[wb_ch][k] <= mem[wb_ch][k-1];
            end
            if (clr_en) begin
                for (int k = 0; k < ORDER; k++)
                    mem[clr_ch][k] <= '0;
            end
        end
    end

    // Present the selected channel's history.
    always_comb begin
        for (int k = 0; k < ORDER; k++)
            rd_hist[k] = mem[rd_ch][k];
    end
endmodule

// File: rtl/iir_mac_pipe.sv
// Multiply-accumulate pipeline: one register of ten parallel products,
// one register of the summed accumulator, then LAT-3 delay registers so
// the caller's output register completes a total of LAT stages.
// The wb_* outputs are the rounded result one cycle before the output.
module iir_mac_pipe
    import chan_iir_pkg::*;
#(
    parameter int LAT = 6,
    parameter int CHW = 3,
    localparam int NDLY = LAT - 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_v,
    input  logic [CHW-1:0]        in_ch,
    input  logic signed [DW-1:0]  in_x,
    input  logic signed [CW-1:0]  coef [ORDER],
    input  logic signed [DW-1:0]  hist [ORDER],
    output logic                  wb_v,
    output logic [CHW-1:0]        wb_ch,
    output logic signed [DW-1:0]  wb_y
);
    logic                 p1_v;
    logic [CHW-1:0]       p1_ch;
    logic signed [AW-1:0] p1_x;
    logic signed [AW-1:0] p1_prod [ORDER];
    logic signed [AW-1:0] sum_next;
    logic                 s2_v;
    logic [CHW-1:0]       s2_ch;
    logic signed [AW-1:0] s2_acc;
    logic                 d_v   [NDLY];
    logic [CHW-1:0]       d_ch  [NDLY];
    logic signed [AW-1:0] d_acc [NDLY];

    // One registered multiplier per tap.
    for (genvar k = 0; k < ORDER; k++) begin : g_tap
        logic signed [AW-1:0] prod_c;
        assign prod_c = AW'(coef[k]) * AW'(hist[k]);
        // Register this tap's product.
        always_ff @(posedge clk) p1_prod[k] <= prod_c;
    end

    // Register the scaled excitation and tag alongside the products.
    always_ff @(posedge clk) begin
        p1_x  <= AW'(in_x) <<< FRAC;
        p1_ch <= in_ch;
    end

    // Subtract all weighted past outputs from the scaled excitation.
    always_comb begin
        sum_next = p1_x;
        for (int k = 0; k < ORDER; k++)
            sum_next = sum_next - p1_prod[k];
    end

    // Accumulator register and delay chain data.
    always_ff @(posedge clk) begin
        s2_acc   <= sum_next;
        s2_ch    <= p1_ch;
        d_acc[0] <= s2_acc;
        d_ch[0]  <= s2_ch;
        for (int i = 1; i < NDLY; i++) begin
            d_acc[i] <= d_acc[i-1];
            d_ch[i]  <= d_ch[i-1];
        end
    end

    // Valid bits through every stage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p1_v <= 1'b0;
            s2_v <= 1'b0;
            for (int i = 0; i < NDLY; i++) d_v[i] <= 1'b0;
        end else begin
            p1_v   <= in_v;
            s2_v   <= p1_v;
            d_v[0] <= s2_v;
            for (int i = 1; i < NDLY; i++) d_v[i] <= d_v[i-1];
        end
    end

    assign wb_v  = d_v[NDLY-1];
    assign wb_ch = d_ch[NDLY-1];
    assign wb_y  = round_sat(d_acc[NDLY-1]);
endmodule

// File: rtl/chan_iir_synth.sv
// Top of the channel-interleaved tenth-order all-pole filter. Accepts one
// tagged sample per cycle and returns the result LAT cycles later. A sample
// whose channel is still in flight is dropped and flagged. Assumes NCH >= LAT
// for full rate and channel tags below NCH.
module chan_iir_synth
    import chan_iir_pkg::*;
#(
    parameter int NCH = 8,
    parameter int LAT = 6,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [CHW-1:0]        in_ch,
    input  logic signed [DW-1:0]  in_x,
    input  logic                  coef_we,
    input  logic [CHW-1:0]        coef_ch,
    input  logic [IDXW-1:0]       coef_idx,
    input  logic signed [CW-1:0]  coef_val,
    input  logic                  clr_en,
    input  logic [CHW-1:0]        clr_ch,
    output logic                  out_valid,
    output logic [CHW-1:0]        out_ch,
    output logic signed [DW-1:0]  out_y,
    output logic                  hazard
);
    if (LAT < 5 || LAT > 12 || NCH < LAT) begin : g_param_bad
        $error("chan_iir_synth: need 5 <= LAT <= 12 and NCH >= LAT");
    end

    logic                 accept;
    logic [NCH-1:0]       pending;
    logic signed [CW-1:0] coef_rd [ORDER];
    logic signed [DW-1:0] hist_rd [ORDER];
    logic                 wb_v;
    logic [CHW-1:0]       wb_ch;
    logic signed [DW-1:0] wb_y;

    assign accept = in_valid && !pending[in_ch];

    iir_coef_store #(.NCH(NCH)) u_coef (
        .clk(clk), .rst_n(rst_n),
        .wr_en(coef_we), .wr_ch(coef_ch), .wr_idx(coef_idx), .wr_val(coef_val),
        .rd_ch(in_ch), .rd_coef(coef_rd)
    );

    iir_hist_store #(.NCH(NCH)) u_hist (
        .clk(clk), .rst_n(rst_n),
        .wb_en(wb_v), .wb_ch(wb_ch), .wb_y(wb_y),
        .clr_en(clr_en), .clr_ch(clr_ch),
        .rd_ch(in_ch), .rd_hist(hist_rd)
    );

    iir_mac_pipe #(.LAT(LAT), .CHW(CHW)) u_pipe (
        .clk(clk), .rst_n(rst_n),
        .in_v(accept), .in_ch(in_ch), .in_x(in_x),
        .coef(coef_rd), .hist(hist_rd),
        .wb_v(wb_v), .wb_ch(wb_ch), .wb_y(wb_y)
    );

    // Track channels with a result in flight; flag refused samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            hazard  <= 1'b0;
        end else begin
            if (wb_v)   pending[wb_ch] <= 1'b0;
            if (accept) pending[in_ch] <= 1'b1;
            hazard <= in_valid && pending[in_ch];
        end
    end

    // Output register, loaded at the same edge as the history write-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_ch    <= '0;
            out_y     <= '0;
        end else begin
            out_valid <= wb_v;
            out_ch    <= wb_ch;
            out_y     <= wb_y;
        end
    end
endmodule

// File: rtl/chan_iir_synth_chk.sv
// Timing checker for chan_iir_synth. Keeps its own record of accepted
// samples from the port view and checks output timing, tags and the
// refusal flag against it.
module chan_iir_synth_chk #(
    parameter int NCH = 8,
    parameter int LAT = 6,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic           in_valid,
    input logic [CHW-1:0] in_ch,
    input logic           out_valid,
    input logic [CHW-1:0] out_ch,
    input logic           hazard
);
    logic           sr_v  [LAT];
    logic [CHW-1:0] sr_ch [LAT];
    logic           hit;
    logic           hit_q;

    // A sample collides if its channel was accepted in the last LAT-1 cycles.
    always_comb begin
        hit = 1'b0;
        for (int j = 0; j < LAT - 1; j++)
            if (sr_v[j] && sr_ch[j] == in_ch) hit = 1'b1;
    end

    // Shift record of accepted samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < LAT; j++) begin
                sr_v[j]  <= 1'b0;
                sr_ch[j] <= '0;
            end
            hit_q <= 1'b0;
        end else begin
            sr_v[0]  <= in_valid && !hit;
            sr_ch[0] <= in_ch;
            for (int j = 1; j < LAT; j++) begin
                sr_v[j]  <= sr_v[j-1];
                sr_ch[j] <= sr_ch[j-1];
            end
            hit_q <= in_valid && hit;
        end
    end

    assert_out_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == sr_v[LAT-1]);

    assert_out_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_ch == sr_ch[LAT-1]);

    assert_hazard_match_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hazard == hit_q);

    assert_hazard_needs_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hazard |-> $past(in_valid));
endmodule

bind chan_iir_synth chan_iir_synth_chk #(.NCH(NCH), .LAT(LAT)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch),
    .out_valid(out_valid), .out_ch(out_ch), .hazard(hazard)
);

// File: tb/chan_iir_synth_tb_top.sv
// Self-checking bench: a localparam stimulus table streamed round-robin,
// then directed tests for reset, refusal, coefficient timing, clear and
// saturation. Expected results come from an independent arithmetic model.
module chan_iir_synth_tb_top;
    localparam int NCH = 8;
    localparam int LAT = 6;
    localparam int CHW = 3;
    localparam int NB  = 32;
    localparam logic signed [15:0] STIM [16] = '{
        16'sd1200, -16'sd3400, 16'sd250, 16'sd7000, -16'sd120, 16'sd0,
        -16'sd9000, 16'sd4321, 16'sd15, -16'sd2048, 16'sd600, 16'sd3000,
        -16'sd777, 16'sd12000, -16'sd50, 16'sd99 };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, coef_we = 1'b0, clr_en = 1'b0;
    logic [CHW-1:0] in_ch = '0, coef_ch = '0, clr_ch = '0;
    logic signed [15:0] in_x = '0, coef_val = '0;
    logic [3:0] coef_idx = '0;
    logic out_valid, hazard;
    logic [CHW-1:0] out_ch;
    logic signed [15:0] out_y;

    chan_iir_synth #(.NCH(NCH), .LAT(LAT)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch), .in_x(in_x),
        .coef_we(coef_we), .coef_ch(coef_ch), .coef_idx(coef_idx), .coef_val(coef_val),
        .clr_en(clr_en), .clr_ch(clr_ch),
        .out_valid(out_valid), .out_ch(out_ch), .out_y(out_y), .hazard(hazard));

    always #10 clk = ~clk;

    int checks = 0, fails = 0, s = 0;
    int m_c [NCH][10];
    int m_h [NCH][10];
    int last [NCH];
    bit exp_v [NB];
    bit hz_e [NB];
    int exp_ch [NB];
    logic signed [15:0] exp_y [NB];
    string exp_tag [NB];
    string cur_tag = "R1";

    // Model of the recursion (R2): 32-bit wrap, round half up, saturate (R9).
    function automatic logic signed [15:0] model_y(int ch, int x);
        longint acc = longint'(x) * 4096;
        int a32;
        longint r;
        for (int k = 0; k < 10; k++) acc -= longint'(m_c[ch][k]) * longint'(m_h[ch][k]);
        a32 = int'(acc);
        r = (longint'(a32) + 2048) >>> 12;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return 16'(r);
    endfunction

    // One cycle: check this cycle's outputs, update the model, drive inputs.
    task automatic step(bit iv, int ich, int ix, bit cwv, int cch, int cidx, int cval,
                        bit clv, int clch);
        int sl = s % NB;
        logic signed [15:0] y;
        checks++;
        if (out_valid !== exp_v[sl] || hazard !== hz_e[sl] ||
            (exp_v[sl] && (out_ch !== CHW'(exp_ch[sl]) || out_y !== exp_y[sl]))) begin
            fails++;
            $display("FAIL %s cycle %0d: got v=%0b ch=%0d y=%0d hz=%0b, expected v=%0b ch=%0d y=%0d hz=%0b",
                     exp_tag[sl], s, out_valid, out_ch, out_y, hazard,
                     exp_v[sl], exp_ch[sl], exp_y[sl], hz_e[sl]);
        end
        exp_v[sl] = 0; hz_e[sl] = 0; exp_tag[sl] = "R1";
        if (iv) begin
            if (s - last[ich] < LAT) begin
                hz_e[(s+1)%NB] = 1;
                exp_tag[(s+1)%NB] = "R5";
                exp_tag[(s+LAT)%NB] = "R5";
            end else begin
                y = model_y(ich, ix);
                exp_v[(s+LAT)%NB] = 1;
                exp_ch[(s+LAT)%NB] = ich;
                exp_y[(s+LAT)%NB] = y;
                exp_tag[(s+LAT)%NB] = cur_tag;
                last[ich] = s;
                for (int k = 9; k > 0; k--) m_h[ich][k] = m_h[ich][k-1];
                m_h[ich][0] = int'(y);
            end
        end
        if (cwv && cidx >= 1 && cidx <= 10) m_c[cch][cidx-1] = cval;
        if (clv) for (int k = 0; k < 10; k++) m_h[clch][k] = 0;
        in_valid = iv; in_ch = CHW'(ich); in_x = 16'(ix);
        coef_we = cwv; coef_ch = CHW'(cch); coef_idx = 4'(cidx); coef_val = 16'(cval);
        clr_en = clv; clr_ch = CHW'(clch);
        @(posedge clk);
        #1;
        s++;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic sample(int ch, int x);
        step(1, ch, x, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic wcoef(int ch, int idx, int val);
        step(0, 0, 0, 1, ch, idx, val, 0, 0);
    endtask

    // Explicit value check on a model-free expectation (R9 rails).
    task automatic expect_val(string tag, logic signed [15:0] got, logic signed [15:0] want);
        checks++;
        if (got !== want) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", tag, got, want);
        end
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic signed [15:0] cap;
        for (int c = 0; c < NCH; c++) begin
            last[c] = -100;
            for (int k = 0; k < 10; k++) begin m_c[c][k] = 0; m_h[c][k] = 0; end
        end
        for (int i = 0; i < NB; i++) begin
            exp_v[i] = 0; hz_e[i] = 0; exp_tag[i] = "R8";
        end
        repeat (4) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R8: reset state, zero coefficients give y = x on first samples.
        cur_tag = "R8 R2";
        for (int c = 0; c < NCH; c++) sample(c, 1000 * (c + 1) - 4000);
        idle(LAT + 1);

        // R6 / R3: distinct coefficients per channel.
        for (int c = 0; c < NCH; c++)
            for (int k = 1; k <= 10; k++)
                wcoef(c, k, (k == 1) ? (-1500 + 300 * c) : (((c * 7 + k * 13) % 41) - 20) * 25);

        // R4 / R1 / R2 / R3: full-rate round-robin stream, 40 samples per channel.
        cur_tag = "R4 R1 R2 R3";
        for (int n = 0; n < 40; n++)
            for (int c = 0; c < NCH; c++)
                sample(c, int'(STIM[(n + c) % 16]));
        idle(LAT + 1);

        // R5: a second sample on channel 0 two cycles after the first is refused.
        cur_tag = "R5";
        sample(0, 100);
        idle(1);
        sample(0, 200);
        idle(LAT + 1);
        sample(0, 300);
        idle(LAT + 1);

        // R6: indices 0 and 11 ignored; same-cycle write uses old value.
        cur_tag = "R6";
        wcoef(1, 0, 4000);
        wcoef(1, 11, 4000);
        sample(1, 2500);
        idle(LAT);
        step(1, 1, -1800, 1, 1, 1, 3000, 0, 0);
        idle(LAT);
        sample(1, 900);
        idle(LAT + 1);

        // R7: clear channel 2, next sample returns x exactly; channel 5 keeps history.
        cur_tag = "R7";
        step(0, 0, 0, 0, 0, 0, 0, 1, 2);
        sample(2, 777);
        sample(5, 321);
        idle(LAT - 2);
        expect_val("R7 clear gives y=x", out_y, 16'sd777);
        idle(LAT + 1);

        // R9: feedback near -1.0 drives both rails.
        cur_tag = "R9";
        for (int k = 1; k <= 10; k++) wcoef(3, k, (k == 1) ? -4095 : 0);
        for (int k = 1; k <= 10; k++) wcoef(4, k, (k == 1) ? -4095 : 0);
        step(0, 0, 0, 0, 0, 0, 0, 1, 3);
        step(0, 0, 0, 0, 0, 0, 0, 1, 4);
        sample(3, 32767);
        sample(4, -32768);
        idle(LAT - 2);
        idle(LAT);
        sample(3, 32767);
        sample(4, -32768);
        idle(LAT - 2);
        cap = out_y;
        expect_val("R9 positive rail", cap, 16'sd32767);
        idle(1);
        expect_val("R9 negative rail", out_y, -16'sd32768);
        idle(LAT + 1);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule